// File: doc/BRIEF.md
# Flash Lock Protection and Status Unit

This block is the permission and status core of a flash write controller. A host hands it one operation at a time: erase a block, write a byte, lock a block, lock the whole device at master level, or release every block lock. The unit then stays busy for a fixed number of cycles. At the end of that time it decides whether the operation may proceed. The decision weighs the operation type, a per-block lock bit, a single master lock bit and a high-voltage override on the reset pin. It also checks the programming supply and a flag that marks an improper command sequence. The outcome goes into an 8-bit status register and a ready/busy output.

The lock bits are held inside the unit. Every allowed lock operation changes them, so later requests are judged against the new lock state. Error bits are sticky and collect across operations until the host pulses the clear-status input. The supply and override inputs are looked at only when an operation finishes. Changes on them between operations leave the status alone.

Top module: `flash_lock_guard`

## Requirements
- R1: After reset the status reads 0x80, ready is 1, and every block lock bit and the master lock bit are clear.
- R2: Operation codes on req_op are 0 block erase, 1 byte write, 2 set block lock, 3 set master lock, 4 clear all block locks. Codes 5 to 7 are ignored: ready stays 1 and the status is unchanged.
- R3: A request is taken on a rising edge where req_valid is 1 and ready is 1. Ready is then 0 for exactly BUSY_CYCLES cycles. Requests seen while ready is 0 are ignored.
- R4: Erase and write are allowed when the addressed block's lock bit is clear, or when rst_hv is 1. Otherwise they are refused.
- R5: Set block lock is allowed when the master lock bit is clear, or when rst_hv is 1.
- R6: Set master lock is allowed only when rst_hv is 1, whatever the lock state.
- R7: Clear block locks is allowed when the master lock bit is clear, or when rst_hv is 1.
- R8: Status bit 7 is 1 when ready and 0 when busy, and the ready output always equals it. Bits 6, 2 and 0 always read 0.
- R9: A request taken with bad_seq set is not performed and sets both bit 5 and bit 4. This check has the highest priority.
- R10: If supply_ok is 0 when the operation finishes and bad_seq was clear, the operation is aborted. Bit 3 is set, along with the class error bit: bit 5 for erase and clear-locks, bit 4 for write, set block lock and set master lock. The protection check is then skipped.
- R11: A refused operation sets bit 1 together with its class error bit, using the same class mapping as R10.
- R12: Bits 5, 4, 3 and 1 accumulate by OR and are cleared only by clr_status. When a clear and a finishing operation fall on the same edge, the new errors of that operation remain set.
- R13: req_op, req_block and bad_seq are captured when the request is taken. rst_hv and supply_ok are sampled only on the edge where the operation finishes.
- R14: An allowed set block lock sets the addressed block's lock bit. An allowed set master lock sets the master bit. An allowed clear sets all block bits to 0 and leaves the master bit as it is. Refused or aborted operations change no lock bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Operation request strobe |
| req_op | input | 3 | Operation code (R2) |
| req_block | input | BLK_W | Addressed block index |
| rst_hv | input | 1 | Reset pin held at high voltage (lock override) |
| supply_ok | input | 1 | Programming supply within range |
| bad_seq | input | 1 | Improper command sequence detected |
| clr_status | input | 1 | Clears the sticky error bits |
| status | output | 8 | Status register |
| ready | output | 1 | 1 = ready, 0 = busy |

## Verification
The bench builds the unit with NUM_BLOCKS = 4 and BUSY_CYCLES = 3. With four blocks, one run can lock, unlock and re-lock different blocks and then show that a neighbour was left untouched. With a three-cycle busy window there is room to change supply_ok in the middle of an operation, to send a competing request while busy, and to line a clear-status pulse up with the finishing edge. The ordered vector table walks every row of the permission table under both master states.

// File: rtl/flg_pkg.sv
package flg_pkg;

   typedef enum logic [2:0] {
      OP_ERASE  = 3'd0,
      OP_WRITE  = 3'd1,
      OP_SETBLK = 3'd2,
      OP_SETMST = 3'd3,
      OP_CLRBLK = 3'd4
   } op_e;

   localparam logic [2:0] OP_LAST = 3'd4;

   function automatic logic op_known(input logic [2:0] code);
      return code <= OP_LAST;
   endfunction

   // erase-type class reports through status bit 5, the rest through bit 4
   function automatic logic erase_class(input op_e op);
      return (op == OP_ERASE) || (op == OP_CLRBLK);
   endfunction

endpackage

// File: rtl/flg_sequencer.sv
module flg_sequencer #(
   parameter int unsigned BUSY_CYCLES = 8,
   parameter int unsigned CNT_W       = $clog2(BUSY_CYCLES + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req,
   output logic accept,
   output logic busy,
   output logic done
);

   logic busy_q;

   assign accept = req && !busy_q;
   assign busy   = busy_q;

   generate
      if (BUSY_CYCLES == 1) begin : g_single
         assign done = busy_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      busy_q <= 1'b0;
            else if (accept) busy_q <= 1'b1;
            else if (done)   busy_q <= 1'b0;
         end
      end else begin : g_count
         logic [CNT_W-1:0] cnt_q;
         assign done = busy_q && (cnt_q == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               busy_q <= 1'b0;
               cnt_q  <= '0;
            end else if (accept) begin
               busy_q <= 1'b1;
               cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
            end else if (done) begin
               busy_q <= 1'b0;
            end else if (busy_q) begin
               cnt_q  <= cnt_q - 1'b1;
            end
         end

         AST_BUSY_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
            (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == CNT_W'($past(cnt_q) - 1'b1))); // R3
      end
   endgenerate

   AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !done) |=> busy_q); // R3

endmodule

// File: rtl/flg_permit.sv
module flg_permit
   import flg_pkg::*;
(
   input  op_e  op,
   input  logic blk_lock,
   input  logic mst_lock,
   input  logic hv,
   input  logic sok,
   input  logic bad,
   output logic perform,
   output logic e_eclr,
   output logic e_wset,
   output logic e_vlow,
   output logic e_prot
);

   logic allowed;
   logic ecls;

   assign ecls = erase_class(op);

   always_comb begin
      unique case (op)
         OP_ERASE, OP_WRITE:   allowed = !blk_lock || hv;
         OP_SETBLK, OP_CLRBLK: allowed = !mst_lock || hv;
         OP_SETMST:            allowed = hv;
         default:              allowed = 1'b0;
      endcase
   end

   always_comb begin
      perform = 1'b0;
      e_eclr  = 1'b0;
      e_wset  = 1'b0;
      e_vlow  = 1'b0;
      e_prot  = 1'b0;
      if (bad) begin
         e_eclr = 1'b1;
         e_wset = 1'b1;
      end else if (!sok) begin
         e_vlow = 1'b1;
         e_eclr = ecls;
         e_wset = !ecls;
      end else if (!allowed) begin
         e_prot = 1'b1;
         e_eclr = ecls;
         e_wset = !ecls;
      end else begin
         perform = 1'b1;
      end
   end

endmodule

// File: rtl/flg_lockbits.sv
module flg_lockbits
   import flg_pkg::*;
#(
   parameter int unsigned NUM_BLOCKS = 16,
   parameter int unsigned BLK_W      = $clog2(NUM_BLOCKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd,
   input  op_e              op,
   input  logic [BLK_W-1:0] blk,
   output logic             blk_lock,
   output logic             mst_lock
);

   logic [NUM_BLOCKS-1:0] lock_q;
   logic                  mst_q;

   generate
      for (genvar gi = 0; gi < NUM_BLOCKS; gi++) begin : g_blk
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               lock_q[gi] <= 1'b0;
            else if (upd && op == OP_CLRBLK)
               lock_q[gi] <= 1'b0;
            else if (upd && op == OP_SETBLK && blk == BLK_W'(gi))
               lock_q[gi] <= 1'b1;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       mst_q <= 1'b0;
      else if (upd && op == OP_SETMST)  mst_q <= 1'b1;
   end

   assign blk_lock = lock_q[blk];
   assign mst_lock = mst_q;

   AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !upd |=> ($stable(lock_q) && $stable(mst_q))); // R14

endmodule

// File: rtl/flash_lock_guard.sv
module flash_lock_guard
   import flg_pkg::*;
#(
   parameter int unsigned NUM_BLOCKS  = 16,
   parameter int unsigned BUSY_CYCLES = 8,
   localparam int unsigned BLK_W      = $clog2(NUM_BLOCKS),
   localparam int unsigned CNT_W      = $clog2(BUSY_CYCLES + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [2:0]       req_op,
   input  logic [BLK_W-1:0] req_block,
   input  logic             rst_hv,
   input  logic             supply_ok,
   input  logic             bad_seq,
   input  logic             clr_status,
   output logic [7:0]       status,
   output logic             ready
);

   generate
      if (NUM_BLOCKS < 2 || (1 << BLK_W) != NUM_BLOCKS) begin : g_bad_blocks
         $error("NUM_BLOCKS must be a power of two of at least 2");
      end
      if (BUSY_CYCLES < 1) begin : g_bad_busy
         $error("BUSY_CYCLES must be at least 1");
      end
   endgenerate

   logic             accept, busy, done;
   op_e              op_q;
   logic [BLK_W-1:0] blk_q;
   logic             bad_q;
   logic             blk_lock, mst_lock;
   logic             perform;
   logic             n_eclr, n_wset, n_vlow, n_prot;
   logic [3:0]       e_q;
   logic [3:0]       e_new;

   flg_sequencer #(.BUSY_CYCLES(BUSY_CYCLES), .CNT_W(CNT_W)) u_seq (
      .clk    (clk),
      .rst_n  (rst_n),
      .req    (req_valid && op_known(req_op)),
      .accept (accept),
      .busy   (busy),
      .done   (done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_ERASE;
         blk_q <= '0;
         bad_q <= 1'b0;
      end else if (accept) begin
         op_q  <= op_e'(req_op);
         blk_q <= req_block;
         bad_q <= bad_seq;
      end
   end

   flg_lockbits #(.NUM_BLOCKS(NUM_BLOCKS), .BLK_W(BLK_W)) u_locks (
      .clk      (clk),
      .rst_n    (rst_n),
      .upd      (done && perform),
      .op       (op_q),
      .blk      (blk_q),
      .blk_lock (blk_lock),
      .mst_lock (mst_lock)
   );

   flg_permit u_permit (
      .op       (op_q),
      .blk_lock (blk_lock),
      .mst_lock (mst_lock),
      .hv       (rst_hv),
      .sok      (supply_ok),
      .bad      (bad_q),
      .perform  (perform),
      .e_eclr   (n_eclr),
      .e_wset   (n_wset),
      .e_vlow   (n_vlow),
      .e_prot   (n_prot)
   );

   // e_q order: {erase/clear class, write/set class, supply low, protection}
   assign e_new = done ? {n_eclr, n_wset, n_vlow, n_prot} : 4'b0000;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          e_q <= '0;
      else if (clr_status) e_q <= e_new;
      else                 e_q <= e_q | e_new;
   end

   assign ready  = !busy;
   assign status = {!busy, 1'b0, e_q[3], e_q[2], e_q[1], 1'b0, e_q[0], 1'b0};

   AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_status |=> ((e_q & $past(e_q)) == $past(e_q))); // R12

   AST_ERR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      (!done && !clr_status) |=> $stable(e_q)); // R13

   AST_MASTER_HV: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mst_lock) |-> $past(rst_hv)); // R6

   AST_BAD_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
      (done && bad_q) |=> (status[5] && status[4])); // R9

endmodule

// File: tb/flash_lock_guard_tb.sv
module flash_lock_guard_tb;

   localparam int unsigned NB = 4;
   localparam int unsigned BC = 3;
   localparam int NV = 30;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       req_valid = 1'b0;
   logic [2:0] req_op = 3'd0;
   logic [1:0] req_block = 2'd0;
   logic       rst_hv = 1'b0;
   logic       supply_ok = 1'b1;
   logic       bad_seq = 1'b0;
   logic       clr_status = 1'b0;
   logic [7:0] status;
   logic       ready;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #4 clk = ~clk;

   flash_lock_guard #(.NUM_BLOCKS(NB), .BUSY_CYCLES(BC)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_block(req_block), .rst_hv(rst_hv), .supply_ok(supply_ok),
      .bad_seq(bad_seq), .clr_status(clr_status), .status(status), .ready(ready)
   );

   // row: {op, block, hv, supply_ok, bad_seq, expected status}
   localparam logic [15:0] VEC [NV] = '{
      {3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd2, 2'd1, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 8'h92},
      {3'd0, 2'd1, 1'b0, 1'b1, 1'b0, 8'hA2},
      {3'd0, 2'd1, 1'b1, 1'b1, 1'b0, 8'h80},
      {3'd1, 2'd1, 1'b1, 1'b1, 1'b0, 8'h80},
      {3'd3, 2'd0, 1'b0, 1'b1, 1'b0, 8'h92},
      {3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 8'h80},
      {3'd2, 2'd2, 1'b0, 1'b1, 1'b0, 8'h92},
      {3'd1, 2'd2, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd2, 2'd2, 1'b1, 1'b1, 1'b0, 8'h80},
      {3'd1, 2'd2, 1'b0, 1'b1, 1'b0, 8'h92},
      {3'd4, 2'd0, 1'b0, 1'b1, 1'b0, 8'hA2},
      {3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 8'h92},
      {3'd4, 2'd0, 1'b1, 1'b1, 1'b0, 8'h80},
      {3'd1, 2'd1, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd0, 2'd2, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd3, 2'd0, 1'b1, 1'b1, 1'b0, 8'h80},
      {3'd2, 2'd3, 1'b1, 1'b1, 1'b0, 8'h80},
      {3'd0, 2'd3, 1'b0, 1'b1, 1'b0, 8'hA2},
      {3'd0, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA8},
      {3'd2, 2'd0, 1'b1, 1'b0, 1'b0, 8'h98},
      {3'd1, 2'd0, 1'b0, 1'b1, 1'b0, 8'h80},
      {3'd0, 2'd3, 1'b1, 1'b1, 1'b1, 8'hB0},
      {3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 8'hB0},
      {3'd4, 2'd0, 1'b0, 1'b0, 1'b0, 8'hA8}
   };

   function automatic string tag_of(input logic [2:0] op, input logic sok, input logic bad);
      if (bad)            return "R9";
      if (!sok)           return "R10 R11";
      if (op <= 3'd1)     return "R4 R11";
      if (op == 3'd2)     return "R5 R11 R14";
      if (op == 3'd3)     return "R6 R11 R14";
      return "R7 R11 R14";
   endfunction

   task automatic check8(input logic [7:0] act, input logic [7:0] exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, act, exp);
      end
   endtask

   task automatic pulse_clear();
      @(negedge clk);
      clr_status = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr_status = 1'b0;
   endtask

   // issue one operation and check the busy window length (R3, R8)
   task automatic do_op(input logic [2:0] op, input logic [1:0] blk, input logic hv,
                        input logic sok_req, input logic sok_end, input logic bad,
                        input logic clr_end);
      @(negedge clk);
      req_valid = 1'b1; req_op = op; req_block = blk;
      rst_hv = hv; supply_ok = sok_req; bad_seq = bad;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0; bad_seq = 1'b0; supply_ok = sok_end;
      for (int i = 1; i < BC; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
      check8({7'd0, ready}, 8'd0, "R3 busy window");
      check8({7'd0, status[7]}, {7'd0, ready}, "R8 mirror busy");
      if (clr_end) clr_status = 1'b1;
      @(posedge clk);
      @(negedge clk);
      clr_status = 1'b0;
      check8({7'd0, ready}, 8'd1, "R3 ready after window");
      check8({7'd0, status[7]}, {7'd0, ready}, "R8 mirror ready");
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog: got hung expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check8(status, 8'h80, "R1 reset status");
      check8({7'd0, ready}, 8'd1, "R1 reset ready");

      // R2: undefined codes are ignored
      for (int c = 5; c < 8; c++) begin
         @(negedge clk);
         req_valid = 1'b1; req_op = 3'(c); rst_hv = 1'b1;
         @(posedge clk);
         @(negedge clk);
         req_valid = 1'b0;
         check8({7'd0, ready}, 8'd1, "R2 unknown code ready");
         check8(status, 8'h80, "R2 unknown code status");
      end
      // R2/R14: nothing locked by ignored codes; write to block 0 succeeds
      do_op(3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      check8(status, 8'h80, "R2 R14 lock state after ignored codes");

      // permission table walk
      for (int i = 0; i < NV; i++) begin
         pulse_clear();
         do_op(VEC[i][15:13], VEC[i][12:11], VEC[i][10], VEC[i][9], VEC[i][9],
               VEC[i][8], 1'b0);
         check8(status, VEC[i][7:0], tag_of(VEC[i][15:13], VEC[i][9], VEC[i][8]));
      end
      // state now: master set, block 3 locked

      // R12: errors accumulate without a clear
      pulse_clear();
      do_op(3'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      check8(status, 8'h92, "R12 first error");
      do_op(3'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      check8(status, 8'hB2, "R12 accumulated errors");
      pulse_clear();
      check8(status, 8'h80, "R12 clear status");
      // R12: clear on the finishing edge keeps the new error
      do_op(3'd1, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      do_op(3'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
      check8(status, 8'hA2, "R12 clear coincident with finish");

      // R13: supply sampled at finish only
      pulse_clear();
      do_op(3'd0, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
      check8(status, 8'hA8, "R13 supply drops during busy");
      pulse_clear();
      do_op(3'd0, 2'd0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
      check8(status, 8'h80, "R13 supply recovers before finish");
      @(negedge clk);
      supply_ok = 1'b0; rst_hv = 1'b1;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check8(status, 8'h80, "R13 idle input changes ignored");
      supply_ok = 1'b1; rst_hv = 1'b0;

      // R3: request during busy is ignored (would lock block 0 if taken)
      @(negedge clk);
      req_valid = 1'b1; req_op = 3'd1; req_block = 2'd0; rst_hv = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_op = 3'd2;
      for (int i = 0; i < BC; i++) begin
         @(posedge clk);
         @(negedge clk);
      end
      req_valid = 1'b0;
      check8({7'd0, ready}, 8'd1, "R3 ready after ignored request");
      do_op(3'd1, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
      check8(status, 8'h80, "R3 busy request had no effect");

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule